// File: doc/BRIEF.md
# Advanced Error Status and Logging Unit

This block holds the error-recording state of an endpoint's advanced error reporting structure. Error detectors elsewhere in the port raise single-cycle pulses, one line per error type. There is one 32-bit vector for uncorrectable errors and one for correctable errors. With an uncorrectable pulse comes the 128-bit header of the packet that caused it. The unit keeps these values:

- sticky status bits
- per-bit mask registers
- a per-bit severity register
- a pointer to the first uncorrectable error recorded
- a four-DWORD copy of that error's packet header
- the ECRC generate/check controls

From these it raises fatal, non-fatal and correctable report requests. Those requests are turned into messages further along the path.

Software reaches the state through a plain register port. The port takes a DWORD word index relative to the start of the structure. A write takes effect on the clock edge. Every read returns the addressed word one cycle later. Status registers are cleared by writing 1 to a bit. The first-error record is captured once. It stays frozen until software clears the status bit it points at, so the header log always matches the error named by the pointer.

Top module: `errlog_unit`

## Requirements
- R1: After reset, all status and mask registers read 0 and the severity register reads 0x00062030. The control word reads 0x000000A0 with both capable parameters at 1, the four header-log words read 0, all three report outputs are low, and both ECRC enable outputs are low.
- R2: An uncorrectable pulse sets its status bit if its position is one of 4, 5 or 12 through 21. The bit stays set until it is cleared. Other positions always read 0.
- R3: A correctable pulse sets its status bit if its position is one of 0, 6, 7, 8, 12 or 13. The bit stays set until it is cleared. Other positions always read 0.
- R4: Writing to word 1 (uncorrectable status) or word 4 (correctable status) clears each bit written as 1 and leaves bits written as 0. A pulse in the same cycle as the clear leaves its bit set.
- R5: Word 2 (uncorrectable mask), word 3 (severity) and word 5 (correctable mask) are read/write at implemented positions only; all other positions read 0. A severity bit of 1 means fatal.
- R6: A masked error still sets its status bit. It raises no report and does not change the first-error pointer or header log.
- R7: Each report output pulses in the cycle after the triggering pulse. An unmasked uncorrectable error raises the fatal output if its severity bit is 1 and the non-fatal output if it is 0. An unmasked correctable error raises the correctable output.
- R8: An uncorrectable pulse at bit 19 (ECRC) is dropped entirely while ECRC checking is disabled. It then sets no status, raises no report and captures nothing.
- R9: When no capture is held, the first unmasked uncorrectable error writes its bit number into control bits [4:0]. If several errors arrive in the same cycle, the lowest bit number is used. The same event writes header bits [32k+31:32k] into word 7+k, for k = 0 to 3. Both stay unchanged while the status bit named by the pointer stays set.
- R10: Clearing the status bit named by the pointer re-arms capture for the following cycles. The old pointer and header remain readable until the next capture.
- R11: Control word 6 contains four ECRC fields. Bit 5 (generate capable) and bit 7 (check capable) are read-only from parameters. Bit 6 (generate enable) and bit 8 (check enable) are writable when the matching capability is present, and they drive the two enable outputs.
- R12: The read data port returns, one cycle after the address is presented, the word at that index. Indices 0 and 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unc_evt | input | 32 | Uncorrectable error pulses, one per bit position |
| cor_evt | input | 32 | Correctable error pulses, one per bit position |
| hdr_in | input | 128 | Header of the packet tied to the current uncorrectable pulse |
| reg_addr | input | 4 | DWORD index within the structure |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rpt_fatal | output | 1 | Fatal report request pulse |
| rpt_nonfatal | output | 1 | Non-fatal report request pulse |
| rpt_cor | output | 1 | Correctable report request pulse |
| ecrc_gen_en | output | 1 | ECRC generation enable |
| ecrc_chk_en | output | 1 | ECRC check enable |

## Verification
Several properties are checked on every cycle:

- an incoming pulse always lands in its status bit, even against a clear
- no status bit rises without a pulse
- pointer and header stay frozen while a capture is held
- a correctable or uncorrectable report never appears without a pulse of its kind
- the ECRC status bit never rises while checking is off

Some behaviour can only be shown by the bench's scenarios and its reference model:

- which bit wins when errors coincide
- the exact header words stored
- the moment capture re-arms
- the split between fatal and non-fatal
- masking against capture
- the read-back of every register after long random mixes of pulses and writes

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  localparam int REG_W = 32;
  localparam int PTR_W = 5;

  // implemented positions and reset severity
  localparam logic [REG_W-1:0] UNC_IMPL    = 32'h003F_F030;
  localparam logic [REG_W-1:0] COR_IMPL    = 32'h0000_31C1;
  localparam logic [REG_W-1:0] UNC_SEV_RST = 32'h0006_2030;
  localparam int               ECRC_POS    = 19;

  function automatic logic [PTR_W-1:0] lowest_bit(input logic [REG_W-1:0] v);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) r = PTR_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/errlog_statbank.sv
module errlog_statbank
  import errlog_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] evt,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_bits,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] stat_nxt
);

  logic [REG_W-1:0] kept;

  always_comb begin
    kept     = clr_we ? (stat_q & ~clr_bits) : stat_q;
    stat_nxt = (kept | evt) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt & IMPL)) == $past(evt & IMPL)));  // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));  // R2

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
  import errlog_pkg::*;
#(
  parameter int HDR_DW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_W-1:0]        cand,
  input  logic [REG_W-1:0]        unc_stat_nxt,
  input  logic [HDR_DW*REG_W-1:0] hdr_in,
  output logic [PTR_W-1:0]        fep_q,
  output logic [HDR_DW*REG_W-1:0] hdr_log
);

  logic held_q;
  logic take;

  assign take = !held_q && (|cand);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      fep_q  <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      fep_q  <= lowest_bit(cand);
    end else begin
      held_q <= held_q & unc_stat_nxt[fep_q];
    end
  end

  for (genvar w = 0; w < HDR_DW; w++) begin : g_log
    always_ff @(posedge clk) begin
      if (rst)       hdr_log[w*REG_W +: REG_W] <= '0;
      else if (take) hdr_log[w*REG_W +: REG_W] <= hdr_in[w*REG_W +: REG_W];
    end
  end

  AST_FEP_HELD: assert property (@(posedge clk) disable iff (rst)
    held_q |=> $stable(fep_q));  // R9
  AST_HDR_HELD: assert property (@(posedge clk) disable iff (rst)
    held_q |=> $stable(hdr_log));  // R9
  AST_CAPTURE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (!held_q && (|cand)) |=> held_q);  // R10

endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
  import errlog_pkg::*;
#(
  parameter int   ADDR_W       = 4,
  parameter int   HDR_DW       = 4,
  parameter logic ECRC_GEN_CAP = 1'b1,
  parameter logic ECRC_CHK_CAP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_W-1:0]        unc_evt,
  input  logic [REG_W-1:0]        cor_evt,
  input  logic [HDR_DW*REG_W-1:0] hdr_in,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_we,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    rpt_fatal,
  output logic                    rpt_nonfatal,
  output logic                    rpt_cor,
  output logic                    ecrc_gen_en,
  output logic                    ecrc_chk_en
);

  localparam logic [ADDR_W-1:0] IX_USTAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_UMASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_USEV  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_CSTAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IX_CMASK = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IX_CTRL  = ADDR_W'(6);
  localparam int                IX_HDR0  = 7;

  logic [REG_W-1:0] umask_q, usev_q, cmask_q;
  logic [REG_W-1:0] ustat_q, ustat_nxt, cstat_q, cstat_nxt;
  logic [REG_W-1:0] unc_eff, cor_eff, unc_cand;
  logic [PTR_W-1:0] fep;
  logic [HDR_DW*REG_W-1:0] hdr_log;
  logic [REG_W-1:0] rd_d;
  logic             we_ustat, we_cstat;

  // ECRC errors are dropped while checking is off
  always_comb begin
    unc_eff = unc_evt & UNC_IMPL;
    if (!ecrc_chk_en) unc_eff[ECRC_POS] = 1'b0;
    cor_eff  = cor_evt & COR_IMPL;
    unc_cand = unc_eff & ~umask_q;
  end

  assign we_ustat = reg_we && (reg_addr == IX_USTAT);
  assign we_cstat = reg_we && (reg_addr == IX_CSTAT);

  errlog_statbank #(.IMPL(UNC_IMPL)) u_ustat (
    .clk(clk), .rst(rst), .evt(unc_eff), .clr_we(we_ustat),
    .clr_bits(reg_wdata), .stat_q(ustat_q), .stat_nxt(ustat_nxt)
  );

  errlog_statbank #(.IMPL(COR_IMPL)) u_cstat (
    .clk(clk), .rst(rst), .evt(cor_eff), .clr_we(we_cstat),
    .clr_bits(reg_wdata), .stat_q(cstat_q), .stat_nxt(cstat_nxt)
  );

  errlog_capture #(.HDR_DW(HDR_DW)) u_cap (
    .clk(clk), .rst(rst), .cand(unc_cand), .unc_stat_nxt(ustat_nxt),
    .hdr_in(hdr_in), .fep_q(fep), .hdr_log(hdr_log)
  );

  // software-writable configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      umask_q     <= '0;
      usev_q      <= UNC_SEV_RST;
      cmask_q     <= '0;
      ecrc_gen_en <= 1'b0;
      ecrc_chk_en <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == IX_UMASK) umask_q <= reg_wdata & UNC_IMPL;
      if (reg_addr == IX_USEV)  usev_q  <= reg_wdata & UNC_IMPL;
      if (reg_addr == IX_CMASK) cmask_q <= reg_wdata & COR_IMPL;
      if (reg_addr == IX_CTRL) begin
        ecrc_gen_en <= reg_wdata[6] & ECRC_GEN_CAP;
        ecrc_chk_en <= reg_wdata[8] & ECRC_CHK_CAP;
      end
    end
  end

  // report requests, one cycle after the pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_fatal    <= 1'b0;
      rpt_nonfatal <= 1'b0;
      rpt_cor      <= 1'b0;
    end else begin
      rpt_fatal    <= |(unc_cand & usev_q);
      rpt_nonfatal <= |(unc_cand & ~usev_q);
      rpt_cor      <= |(cor_eff & ~cmask_q);
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (reg_addr)
      IX_USTAT: rd_d = ustat_q;
      IX_UMASK: rd_d = umask_q;
      IX_USEV:  rd_d = usev_q;
      IX_CSTAT: rd_d = cstat_q;
      IX_CMASK: rd_d = cmask_q;
      IX_CTRL:  rd_d = {23'd0, ecrc_chk_en, ECRC_CHK_CAP, ecrc_gen_en, ECRC_GEN_CAP, fep};
      default:  rd_d = '0;
    endcase
    for (int w = 0; w < HDR_DW; w++) begin
      if (reg_addr == ADDR_W'(IX_HDR0 + w)) rd_d = hdr_log[w*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end

  AST_ECRC_GATED: assert property (@(posedge clk) disable iff (rst)
    !ecrc_chk_en |=> !$rose(ustat_q[ECRC_POS]));  // R8
  AST_COR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rpt_cor |-> $past(|(cor_evt & COR_IMPL)));  // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rpt_fatal || rpt_nonfatal) |-> $past(|(unc_evt & ~umask_q)));  // R6

endmodule

// File: tb/errlog_unit_test.sv
module errlog_unit_test;

  localparam logic [31:0] UIMPL = 32'h003F_F030;
  localparam logic [31:0] CIMPL = 32'h0000_31C1;
  localparam logic [31:0] SEVR  = 32'h0006_2030;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  unc_evt = '0, cor_evt = '0, reg_wdata = '0;
  logic [127:0] hdr_in = '0;
  logic [3:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_rdata;
  logic         rpt_fatal, rpt_nonfatal, rpt_cor, ecrc_gen_en, ecrc_chk_en;

  int total = 0;
  int bad = 0;

  // reference state
  logic [31:0] m_ustat, m_umask, m_sev, m_cstat, m_cmask;
  logic        m_gen, m_chk, m_held;
  logic [4:0]  m_fep;
  logic [127:0] m_hdr;

  always #4 clk = ~clk;

  errlog_unit uut (
    .clk(clk), .rst(rst), .unc_evt(unc_evt), .cor_evt(cor_evt), .hdr_in(hdr_in),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rpt_fatal(rpt_fatal), .rpt_nonfatal(rpt_nonfatal), .rpt_cor(rpt_cor),
    .ecrc_gen_en(ecrc_gen_en), .ecrc_chk_en(ecrc_chk_en)
  );

  function automatic logic [4:0] low_pos(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ustat = '0; m_umask = '0; m_sev = SEVR; m_cstat = '0; m_cmask = '0;
    m_gen = 0; m_chk = 0; m_held = 0; m_fep = '0; m_hdr = '0;
  endtask

  // one cycle of stimulus, starting at a falling edge; reports checked at the next one
  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] u, input logic [31:0] c, input logic [127:0] h);
    logic [31:0] eu, cand, nu, nc;
    logic [2:0]  exp_r;
    reg_we = we; reg_addr = a; reg_wdata = d; unc_evt = u; cor_evt = c; hdr_in = h;
    eu = u & UIMPL;
    if (!m_chk) eu[19] = 1'b0;
    cand = eu & ~m_umask;
    exp_r = {|(cand & m_sev), |(cand & ~m_sev), |(c & CIMPL & ~m_cmask)};
    nu = m_ustat; nc = m_cstat;
    if (we && a == 4'd1) nu = nu & ~d;
    if (we && a == 4'd4) nc = nc & ~d;
    nu = (nu | eu) & UIMPL;
    nc = (nc | (c & CIMPL)) & CIMPL;
    if (!m_held && cand != 0) begin
      m_held = 1; m_fep = low_pos(cand); m_hdr = h;
    end else begin
      m_held = m_held & nu[m_fep];
    end
    if (we) begin
      if (a == 4'd2) m_umask = d & UIMPL;
      if (a == 4'd3) m_sev   = d & UIMPL;
      if (a == 4'd5) m_cmask = d & CIMPL;
      if (a == 4'd6) begin m_gen = d[6]; m_chk = d[8]; end
    end
    m_ustat = nu; m_cstat = nc;
    @(negedge clk);
    check("R7 reports {fatal,nonfatal,cor}", {29'd0, rpt_fatal, rpt_nonfatal, rpt_cor}, {29'd0, exp_r});
    reg_we = 0; unc_evt = '0; cor_evt = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, a, '0, '0, '0, '0);
    check(tag, reg_rdata, exp);
  endtask

  task automatic chk_all(input string tag);
    rd(4'd1, m_ustat, {tag, " R2 unc status"});
    rd(4'd2, m_umask, {tag, " R5 unc mask"});
    rd(4'd3, m_sev,   {tag, " R5 severity"});
    rd(4'd4, m_cstat, {tag, " R3 cor status"});
    rd(4'd5, m_cmask, {tag, " R5 cor mask"});
    rd(4'd6, {23'd0, m_chk, 1'b1, m_gen, 1'b1, m_fep}, {tag, " R11 ctrl/pointer"});
    for (int k = 0; k < 4; k++) rd(4'(7 + k), m_hdr[k*32 +: 32], {tag, " R9 header log"});
    rd(4'd0, '0, {tag, " R12 index 0"});
    rd(4'd11, '0, {tag, " R12 index 11"});
    check({tag, " R11 enable outputs"}, {30'd0, ecrc_gen_en, ecrc_chk_en}, {30'd0, m_gen, m_chk});
  endtask

  task automatic ev(input logic [31:0] u, input logic [31:0] c);
    cyc(1'b0, 4'd0, '0, u, c, {$urandom, $urandom, $urandom, $urandom});
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd7031);
    m_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_all("R1 reset");

    // R5: only implemented bits are writable
    cyc(1, 4'd2, 32'hFFFF_FFFF, '0, '0, '0);
    cyc(1, 4'd3, 32'hFFFF_FFFF, '0, '0, '0);
    cyc(1, 4'd5, 32'hFFFF_FFFF, '0, '0, '0);
    chk_all("R5 all-ones");
    cyc(1, 4'd2, 32'h0, '0, '0, '0);
    cyc(1, 4'd3, SEVR, '0, '0, '0);
    cyc(1, 4'd5, 32'h0, '0, '0, '0);

    // R8: ECRC error dropped while checking is off
    ev(32'h0008_0000, '0);
    chk_all("R8 ecrc off");
    cyc(1, 4'd6, 32'h0000_0140, '0, '0, '0);
    ev(32'h0008_0000, '0);
    chk_all("R8 ecrc on");

    // R9 / R10: lowest wins, held, re-armed by clearing the pointed bit
    cyc(1, 4'd1, 32'hFFFF_FFFF, '0, '0, '0);
    ev(32'h0020_5000, '0);
    chk_all("R9 lowest wins");
    ev(32'h0000_0010, '0);
    cyc(1, 4'd1, 32'h0000_0010, '0, '0, '0);
    chk_all("R9 held");
    cyc(1, 4'd1, 32'h0000_1000, '0, '0, '0);
    chk_all("R10 cleared keeps old");
    ev(32'h0000_0020, '0);
    chk_all("R10 rearmed");

    // R6: masked error sets status only
    cyc(1, 4'd1, 32'hFFFF_FFFF, '0, '0, '0);
    cyc(1, 4'd2, 32'h0000_2000, '0, '0, '0);
    ev(32'h0000_2000, '0);
    chk_all("R6 masked");
    ev(32'h0001_0000, '0);
    chk_all("R6 unmasked after masked");

    // R4: pulse beats a same-cycle clear
    cyc(1, 4'd1, 32'hFFFF_FFFF, 32'h0000_8000, '0, '0);
    cyc(1, 4'd4, 32'hFFFF_FFFF, '0, 32'h0000_0040, '0);
    chk_all("R4 set wins");

    // R3: correctable positions
    ev('0, 32'hFFFF_FFFF);
    chk_all("R3 all cor");
    cyc(1, 4'd5, 32'h0000_0001, '0, '0, '0);
    ev('0, 32'h0000_0001);
    chk_all("R3 masked cor");

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6) begin
        ev($urandom & $urandom & $urandom, $urandom & $urandom & $urandom);
      end else if (op < 9) begin
        logic [3:0] a;
        logic [31:0] d;
        a = 4'(1 + ($urandom % 6));
        d = $urandom;
        if (a == 4'd1 || a == 4'd4) d = d | $urandom;
        cyc(1, a, d, ($urandom % 4 == 0) ? ($urandom & $urandom) : '0, '0,
            {$urandom, $urandom, $urandom, $urandom});
      end else begin
        chk_all("R12 random");
      end
    end
    chk_all("R12 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule